// File: doc/BRIEF.md
# SPI input port with maskable interrupt

This block is a 16-input general-purpose input port with an SPI slave port and a change-detect interrupt. When the host pulls chip select low, the block takes a snapshot of the input pins. It stores the snapshot as the captured status and sends it back on the serial output, most significant bit first. During the same frame the host shifts a new interrupt mask in on the serial input. That mask takes effect when chip select goes high again.

The interrupt output is active low. It asserts once any enabled input moves away from its captured status. It stays asserted until the next frame begins or until every input is back at its captured value. If the host commits a mask of all zeros, the block treats it as a software reset.

SPI clock, chip select, serial input and the input pins all pass through two-flop synchronizers into the system clock. Every state element runs on that one clock. The serial output has a separate enable, which an external pad would use for tri-stating.

Top module: `spi_gpi_int`

## Requirements
- R1: After hardware reset, irq_no is high and the mask holds zero, so changes on gpi_i do not pull irq_no low.
- R2: sdo_oe_o is low while cs_ni is high and high while cs_ni is low (after synchronizer delay).
- R3: On the falling edge of cs_ni the block captures gpi_i as the status. The same value is shifted out on sdo_o, bit 15 first. Each bit is valid before a rising sclk_i, and sdo_o moves to the next bit after the falling sclk_i.
- R4: sdi_i is sampled on each rising sclk_i, first bit into the top. On the rising edge of cs_ni, the last 16 bits received become the mask, with the first received bit at mask bit 15.
- R5: When an input whose mask bit is 1 differs from its captured status bit, irq_no goes low.
- R6: A difference on an input whose mask bit is 0 leaves irq_no unchanged.
- R7: A falling cs_ni clears the interrupt. The status is recaptured at the same moment.
- R8: The interrupt clears once every input again equals its captured status bit.
- R9: Once set, the interrupt stays low while any input, masked or not, still differs from the status.
- R10: The block does not align the mask. For a frame of K < 16 bits, the committed mask is the snapshot shifted up by K, with the K received bits in the low positions.
- R11: A committed mask of all zeros clears the status, forces irq_no high and leaves the mask at zero.
- R12: A clear event takes priority over a set condition in the same cycle. This holds for both a chip-select fall and a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idles low |
| cs_ni | input | 1 | SPI chip select, active low |
| sdi_i | input | 1 | Serial data in (mask) |
| sdo_o | output | 1 | Serial data out (input snapshot) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| gpi_i | input | 16 | General-purpose input pins |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Two conflicts matter most, because each one puts a clear and a set of the interrupt flag in the same cycle. The first is a chip-select fall that happens together with a change on an enabled input. The bench drives the input change and the chip-select fall in the same step, so both reach the flag through identical synchronizer depth. The bench then expects irq_no to stay high and the new value to appear in the shifted-out snapshot. The second is an all-zero commit that arrives while an enabled input is already pulling irq_no low under the old mask. The bench expects irq_no to return high at the commit and to stay high when inputs toggle afterwards.

// File: rtl/spi_gpi_pkg.sv
`timescale 1ns/1ps
package spi_gpi_pkg;
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic sclk_fall;
  } spi_evt_t;
endpackage

// File: rtl/spi_gpi_sync.sv
`timescale 1ns/1ps
module spi_gpi_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_gpi_frontend.sv
`timescale 1ns/1ps
module spi_gpi_frontend import spi_gpi_pkg::*; #(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_i,
  input  logic     cs_ni,
  input  logic     sdi_i,
  output spi_evt_t evt_o,
  output logic     active_o,
  output logic     sdi_o
);
  logic [2:0] pin_s;
  logic sclk_s, csn_s;
  logic sclk_prev_q, csn_prev_q;

  // order {sdi, cs_n, sclk}; cs_n idles high
  spi_gpi_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, cs_ni, sclk_i}),
    .q_o   (pin_s)
  );

  assign sclk_s = pin_s[0];
  assign csn_s  = pin_s[1];
  assign sdi_o  = pin_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      csn_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      csn_prev_q  <= csn_s;
    end
  end

  assign active_o        = ~csn_s;
  assign evt_o.cs_fall   = csn_prev_q & ~csn_s;
  assign evt_o.cs_rise   = ~csn_prev_q & csn_s;
  assign evt_o.sclk_rise = active_o & sclk_s & ~sclk_prev_q;
  assign evt_o.sclk_fall = active_o & ~sclk_s & sclk_prev_q;
endmodule

// File: rtl/spi_gpi_shreg.sv
`timescale 1ns/1ps
module spi_gpi_shreg import spi_gpi_pkg::*; #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  spi_evt_t     evt_i,
  input  logic         sdi_i,
  input  logic [N-1:0] load_i,
  output logic [N-1:0] data_o,
  output logic         sdo_o
);
  logic [N-1:0] sreg_q;
  logic         sdi_q;

  // mode 0: sample on rise, advance on fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      sdi_q  <= 1'b0;
    end else if (evt_i.cs_fall) begin
      sreg_q <= load_i;
    end else if (evt_i.sclk_rise) begin
      sdi_q <= sdi_i;
    end else if (evt_i.sclk_fall) begin
      sreg_q <= {sreg_q[N-2:0], sdi_q};
    end
  end

  assign data_o = sreg_q;
  assign sdo_o  = sreg_q[N-1];

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.cs_fall |=> sdo_o == $past(load_i[N-1]));
  a_r4_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.sclk_fall && !evt_i.cs_fall) |=> data_o[N-1:1] == $past(data_o[N-2:0]));
endmodule

// File: rtl/spi_gpi_irq.sv
`timescale 1ns/1ps
module spi_gpi_irq import spi_gpi_pkg::*; #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  spi_evt_t     evt_i,
  input  logic [N-1:0] gpi_i,
  input  logic [N-1:0] shift_i,
  output logic         irq_n_o
);
  logic [N-1:0] mask_q, status_q;
  logic         irq_q;
  logic         soft_rst, hit, match;

  assign soft_rst = evt_i.cs_rise && (shift_i == '0);
  assign hit      = |((gpi_i ^ status_q) & mask_q);
  assign match    = (gpi_i == status_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else if (evt_i.cs_fall) begin
      status_q <= gpi_i;
      irq_q    <= 1'b0;
    end else begin
      if (evt_i.cs_rise) mask_q <= shift_i;
      if (soft_rst) begin
        status_q <= '0;
        irq_q    <= 1'b0;
      end else if (match) begin
        irq_q <= 1'b0;
      end else if (hit) begin
        irq_q <= 1'b1;
      end
    end
  end

  assign irq_n_o = ~irq_q;

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.cs_fall && !soft_rst && hit) |=> !irq_n_o);
  a_r7_cs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.cs_fall |=> irq_n_o);
  a_r8_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> irq_n_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && !evt_i.cs_fall && !soft_rst && !match) |=> !irq_n_o);
  a_r11_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (irq_n_o && mask_q == '0 && status_q == '0));
endmodule

// File: rtl/spi_gpi_int.sv
`timescale 1ns/1ps
module spi_gpi_int import spi_gpi_pkg::*; #(
  parameter int unsigned N_IN = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            cs_ni,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  input  logic [N_IN-1:0] gpi_i,
  output logic            irq_no
);
  spi_evt_t        evt;
  logic            active, sdi_s;
  logic [N_IN-1:0] gpi_s, shift_data;

  spi_gpi_frontend #(.STAGES(SYNC_STAGES)) u_fe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .cs_ni   (cs_ni),
    .sdi_i   (sdi_i),
    .evt_o   (evt),
    .active_o(active),
    .sdi_o   (sdi_s)
  );

  spi_gpi_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gpi_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpi_i),
    .q_o   (gpi_s)
  );

  spi_gpi_shreg #(.N(N_IN)) u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .sdi_i (sdi_s),
    .load_i(gpi_s),
    .data_o(shift_data),
    .sdo_o (sdo_o)
  );

  spi_gpi_irq #(.N(N_IN)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .gpi_i  (gpi_s),
    .shift_i(shift_data),
    .irq_n_o(irq_no)
  );

  assign sdo_oe_o = active;
endmodule

// File: tb/tb_spi_gpi_int.sv
`timescale 1ns/1ps
module tb_spi_gpi_int;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [15:0] gpi = 16'h0000;
  logic        sdo, sdo_oe, irq_n;
  int          checks = 0;
  int          fails = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  spi_gpi_int dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk),
    .cs_ni   (cs_n),
    .sdi_i   (sdi),
    .sdo_o   (sdo),
    .sdo_oe_o(sdo_oe),
    .gpi_i   (gpi),
    .irq_no  (irq_n)
  );

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frame_begin();
    cs_n = 1'b0;
    settle(8);
  endtask

  task automatic frame_end();
    cs_n = 1'b1;
    settle(8);
  endtask

  task automatic shift_bits(int nbits, logic [15:0] mosi, output logic [15:0] miso);
    miso = '0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = mosi[i];
      settle(6);
      miso[i] = sdo;
      sclk = 1'b1;
      settle(6);
      sclk = 1'b0;
    end
    settle(6);
  endtask

  task automatic set_gpi(logic [15:0] v);
    gpi = v;
    settle(6);
  endtask

  task automatic write_mask(logic [15:0] m, logic [15:0] exp_snap, string req);
    logic [15:0] miso;
    frame_begin();
    shift_bits(16, m, miso);
    check(req, "snapshot", miso, exp_snap);
    frame_end();
  endtask

  task automatic t_reset();
    check("R1", "irq after reset", 16'(irq_n), 16'h1);
    check("R2", "oe idle", 16'(sdo_oe), 16'h0);
    set_gpi(16'hFFFF);
    check("R1", "irq with zero mask", 16'(irq_n), 16'h1);
    set_gpi(16'h0000);
  endtask

  task automatic t_frame();
    logic [15:0] miso;
    set_gpi(16'hA5C3);
    frame_begin();
    check("R2", "oe in frame", 16'(sdo_oe), 16'h1);
    shift_bits(16, 16'h0F0F, miso);
    check("R3", "snapshot msb first", miso, 16'hA5C3);
    frame_end();
    check("R2", "oe after frame", 16'(sdo_oe), 16'h0);
    check("R8", "irq idle after commit", 16'(irq_n), 16'h1);
  endtask

  task automatic t_enabled();
    set_gpi(gpi ^ 16'h0001);
    check("R5", "enabled change", 16'(irq_n), 16'h0);
    set_gpi(gpi ^ 16'h0001);
    check("R8", "returned to status", 16'(irq_n), 16'h1);
  endtask

  task automatic t_disabled();
    set_gpi(gpi ^ 16'h0010);
    check("R6", "masked change", 16'(irq_n), 16'h1);
    set_gpi(gpi ^ 16'h0010);
  endtask

  task automatic t_latched();
    set_gpi(gpi ^ 16'h0011);
    check("R5", "enabled plus masked", 16'(irq_n), 16'h0);
    set_gpi(gpi ^ 16'h0001);
    check("R9", "masked diff keeps irq", 16'(irq_n), 16'h0);
    set_gpi(gpi ^ 16'h0010);
    check("R8", "all back", 16'(irq_n), 16'h1);
  endtask

  task automatic t_cs_clear();
    logic [15:0] miso;
    logic [15:0] snap;
    set_gpi(gpi ^ 16'h0100);
    snap = gpi;
    check("R5", "bit 8 enabled", 16'(irq_n), 16'h0);
    frame_begin();
    check("R7", "cleared by cs fall", 16'(irq_n), 16'h1);
    shift_bits(16, 16'hFFFF, miso);
    check("R3", "snapshot", miso, snap);
    frame_end();
    check("R7", "status recaptured", 16'(irq_n), 16'h1);
    set_gpi(gpi ^ 16'h8000);
    check("R4", "new mask bit 15 live", 16'(irq_n), 16'h0);
    set_gpi(gpi ^ 16'h8000);
    check("R8", "bit 15 back", 16'(irq_n), 16'h1);
  endtask

  task automatic t_misaligned();
    logic [15:0] miso;
    set_gpi(16'h0000);
    frame_begin();
    shift_bits(8, 16'h00FF, miso);
    check("R3", "short frame top byte", miso & 16'hFF00, 16'h0000);
    frame_end();
    check("R10", "idle after short frame", 16'(irq_n), 16'h1);
    set_gpi(16'h0100);
    check("R10", "bit 8 masked", 16'(irq_n), 16'h1);
    set_gpi(16'h0001);
    check("R10", "bit 0 enabled", 16'(irq_n), 16'h0);
    set_gpi(16'h0000);
    check("R8", "back to zero", 16'(irq_n), 16'h1);
  endtask

  task automatic t_fall_collision();
    logic [15:0] miso;
    write_mask(16'hFFFF, 16'h0000, "R4");
    gpi = 16'h0040;
    cs_n = 1'b0;
    settle(8);
    check("R12", "cs fall beats set", 16'(irq_n), 16'h1);
    shift_bits(16, 16'hFFFF, miso);
    check("R12", "snapshot has new value", miso, 16'h0040);
    frame_end();
    check("R7", "irq idle after frame", 16'(irq_n), 16'h1);
  endtask

  task automatic t_soft_reset();
    logic [15:0] miso;
    frame_begin();
    shift_bits(16, 16'h0000, miso);
    check("R3", "snapshot", miso, 16'h0040);
    set_gpi(gpi ^ 16'h0001);
    check("R5", "old mask active in frame", 16'(irq_n), 16'h0);
    frame_end();
    check("R12", "soft reset beats set", 16'(irq_n), 16'h1);
    set_gpi(16'hFFFF);
    check("R11", "mask zero after soft reset", 16'(irq_n), 16'h1);
    set_gpi(16'h0000);
    check("R11", "still idle", 16'(irq_n), 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_ni = 1'b1;
    settle(4);
    t_reset();
    t_frame();
    t_enabled();
    t_disabled();
    t_latched();
    t_cs_clear();
    t_misaligned();
    t_fall_collision();
    t_soft_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule